// File: doc/BRIEF.md
# Shared Adder Call Handshake

Two cooperating state machines share one adder. The caller state machine needs the adder at two separate points in its sequence. It reaches both through one callee state machine, so the adder hardware is not built twice. Call and return have no dedicated opcodes or strobes. The caller starts a call by raising the callee's reset line while it loads the two argument registers. It then drops that line and spins in a wait state. The callee signals a return by setting its own finish register. It holds the sum on its return bus during that cycle.

The caller's sequence is fixed by three parameters. The first call adds `FIRST_A` and `FIRST_B`. The second call adds that result and `SECOND_B`. The caller then raises its own `done` output for one cycle, with the final sum on `result`, and parks in a terminal state. Between calls the caller keeps the callee's reset line high, which holds the callee in its entry state. The callee therefore produces exactly one finish pulse for each call and none at any other time.

Top module: `shared_call_top`

## Requirements
- R1: While the global reset `rst` is high, and on the first cycle after it, `done` is 0 and `result` is 0.
- R2: Whenever the callee reset line is high, the callee goes to its entry state on the next edge and its finish flag reads 0. The caller holds that line high in every state except its two wait states.
- R3: A call state raises the callee reset line and, in the same edge, loads both callee argument registers. The first cycle of each wait state sees the reset line still high, and the following cycle sees it low.
- R4: In a wait state the caller loads the callee's return bus into a local capture register on every edge. It stays in the same state while the finish flag is low, and leaves on the edge where the finish flag is high. The capture from that edge equals the return bus value seen with the finish flag.
- R5: Once released, the callee registers the sum of its arguments modulo 2^WIDTH in one state. In the next state it sets the finish flag and copies the sum to its return bus. The flag is high for exactly one cycle, and the callee then idles.
- R6: `result` equals (FIRST_A + FIRST_B + SECOND_B) modulo 2^WIDTH when `done` is high, and keeps that value afterwards until the next global reset.
- R7: After `rst` falls, `done` is high only in the cycle after the 16th rising clock edge. It is high for exactly one cycle and stays low afterwards.
- R8: The callee finish flag pulses exactly twice per sequence, and only while the caller is in a wait state. When `done` rises, both returns have already happened.
- R9: A global reset asserted at any point in the sequence, including mid-call, restarts both machines. The next run gives the same `done` timing and `result` as a run from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous global reset, active high |
| done | output | 1 | Caller finish flag, one-cycle pulse at the end of the sequence |
| result | output | WIDTH | Final sum, valid with `done` and held afterwards |

## Verification
The bench aims at the wait states. A caller that moves on before the finish flag, or that samples the return bus one cycle late, would produce `done` at the wrong cycle or a wrong `result`. A spurious finish pulse from a callee that runs while nobody calls it would be taken as a return too early. A design that does not clear the finish flag, or that restarts badly after reset, would fail the reset sweep. That sweep raises the global reset at every cycle offset of a run and then checks that the next run is identical to one from power-up. Two more instances use narrow and saturated operands, so that a sum that does not wrap modulo 2^WIDTH, or an argument swapped with another, changes the visible result.

// File: rtl/shared_call_pkg.sv
package shared_call_pkg;

  typedef enum logic [1:0] {
    CE_ENTRY = 2'd0,
    CE_FIN   = 2'd1,
    CE_IDLE  = 2'd2
  } callee_st_t;

  typedef enum logic [3:0] {
    CR_INIT  = 4'd0,
    CR_SET0  = 4'd1,
    CR_CALL0 = 4'd2,
    CR_WAIT0 = 4'd3,
    CR_MOVE0 = 4'd4,
    CR_SET1  = 4'd5,
    CR_CALL1 = 4'd6,
    CR_WAIT1 = 4'd7,
    CR_MOVE1 = 4'd8,
    CR_OUT   = 4'd9,
    CR_END   = 4'd10
  } caller_st_t;

  localparam int unsigned CALLER_ST_W = 4;

endpackage

// File: rtl/callee_adder_fsm.sv
module callee_adder_fsm
  import shared_call_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_rst,
  input  logic [WIDTH-1:0] arg_a,
  input  logic [WIDTH-1:0] arg_b,
  output logic             fin,
  output logic [WIDTH-1:0] ret
);

  function automatic logic [WIDTH-1:0] wrap_sum(input logic [WIDTH-1:0] x,
                                                input logic [WIDTH-1:0] y);
    return x + y;
  endfunction

  callee_st_t      st;
  logic [WIDTH-1:0] sum_q;
  logic            home;

  assign home = rst | call_rst;

  // Control: either reset source sends the machine to its entry state.
  always_ff @(posedge clk) begin
    if (home) begin
      st  <= CE_ENTRY;
      fin <= 1'b0;
    end else begin
      case (st)
        CE_ENTRY: st <= CE_FIN;
        CE_FIN: begin
          fin <= 1'b1;
          st  <= CE_IDLE;
        end
        default: begin
          fin <= 1'b0;
          st  <= CE_IDLE;
        end
      endcase
    end
  end

  // Data: cleared only by the global reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      ret   <= '0;
    end else if (!call_rst) begin
      if (st == CE_ENTRY) sum_q <= wrap_sum(arg_a, arg_b);
      if (st == CE_FIN)   ret   <= sum_q;
    end
  end

endmodule

// File: rtl/caller_seq_fsm.sv
module caller_seq_fsm
  import shared_call_pkg::*;
#(
  parameter int unsigned      WIDTH    = 32,
  parameter logic [WIDTH-1:0] FIRST_A  = '0,
  parameter logic [WIDTH-1:0] FIRST_B  = WIDTH'(1),
  parameter logic [WIDTH-1:0] SECOND_B = WIDTH'(2)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   callee_fin,
  input  logic [WIDTH-1:0]       callee_ret,
  output logic                   call_rst,
  output logic [WIDTH-1:0]       arg_a,
  output logic [WIDTH-1:0]       arg_b,
  output logic [WIDTH-1:0]       capture,
  output logic [CALLER_ST_W-1:0] state_code,
  output logic                   waiting,
  output logic                   done,
  output logic [WIDTH-1:0]       result
);

  caller_st_t       st;
  logic [WIDTH-1:0] acc;
  logic [WIDTH-1:0] k;

  assign state_code = st;
  assign waiting    = (st == CR_WAIT0) || (st == CR_WAIT1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CR_INIT;
      call_rst <= 1'b1;
      arg_a    <= '0;
      arg_b    <= '0;
      acc      <= '0;
      k        <= '0;
      capture  <= '0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      case (st)
        CR_INIT: begin
          acc      <= FIRST_A;
          call_rst <= 1'b1;
          st       <= CR_SET0;
        end
        CR_SET0: begin
          k  <= FIRST_B;
          st <= CR_CALL0;
        end
        CR_CALL0, CR_CALL1: begin
          call_rst <= 1'b1;
          arg_a    <= acc;
          arg_b    <= k;
          st       <= (st == CR_CALL0) ? CR_WAIT0 : CR_WAIT1;
        end
        CR_WAIT0, CR_WAIT1: begin
          call_rst <= 1'b0;
          capture  <= callee_ret;
          if (callee_fin) st <= (st == CR_WAIT0) ? CR_MOVE0 : CR_MOVE1;
        end
        CR_MOVE0: begin
          acc      <= capture;
          call_rst <= 1'b1;
          st       <= CR_SET1;
        end
        CR_SET1: begin
          k  <= SECOND_B;
          st <= CR_CALL1;
        end
        CR_MOVE1: begin
          acc      <= capture;
          call_rst <= 1'b1;
          st       <= CR_OUT;
        end
        CR_OUT: begin
          done   <= 1'b1;
          result <= acc;
          st     <= CR_END;
        end
        default: begin
          done <= 1'b0;
          st   <= CR_END;
        end
      endcase
    end
  end

endmodule

// File: rtl/shared_call_top.sv
module shared_call_top
  import shared_call_pkg::*;
#(
  parameter int unsigned      WIDTH    = 32,
  parameter logic [WIDTH-1:0] FIRST_A  = '0,
  parameter logic [WIDTH-1:0] FIRST_B  = WIDTH'(1),
  parameter logic [WIDTH-1:0] SECOND_B = WIDTH'(2)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  logic                   call_rst;
  logic [WIDTH-1:0]       arg_a;
  logic [WIDTH-1:0]       arg_b;
  logic                   callee_fin;
  logic [WIDTH-1:0]       callee_ret;
  logic [WIDTH-1:0]       capture;
  logic [CALLER_ST_W-1:0] caller_state;
  logic                   caller_waiting;

  caller_seq_fsm #(
    .WIDTH(WIDTH), .FIRST_A(FIRST_A), .FIRST_B(FIRST_B), .SECOND_B(SECOND_B)
  ) u_caller (
    .clk        (clk),
    .rst        (rst),
    .callee_fin (callee_fin),
    .callee_ret (callee_ret),
    .call_rst   (call_rst),
    .arg_a      (arg_a),
    .arg_b      (arg_b),
    .capture    (capture),
    .state_code (caller_state),
    .waiting    (caller_waiting),
    .done       (done),
    .result     (result)
  );

  callee_adder_fsm #(.WIDTH(WIDTH)) u_callee (
    .clk      (clk),
    .rst      (rst),
    .call_rst (call_rst),
    .arg_a    (arg_a),
    .arg_b    (arg_b),
    .fin      (callee_fin),
    .ret      (callee_ret)
  );

endmodule

// File: rtl/shared_call_checker.sv
module shared_call_checker
  import shared_call_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   done,
  input logic [WIDTH-1:0]       result,
  input logic                   call_rst,
  input logic [WIDTH-1:0]       arg_a,
  input logic [WIDTH-1:0]       arg_b,
  input logic                   callee_fin,
  input logic [WIDTH-1:0]       callee_ret,
  input logic [WIDTH-1:0]       capture,
  input logic [CALLER_ST_W-1:0] caller_state,
  input logic                   caller_waiting
);

  logic [1:0] fin_count;

  always_ff @(posedge clk) begin
    if (rst) fin_count <= 2'd0;
    else if (callee_fin && fin_count != 2'd3) fin_count <= fin_count + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!done && result == '0));

  assert_callee_home_R2: assert property (@(posedge clk) disable iff (rst)
    call_rst |=> !callee_fin);

  assert_park_R2: assert property (@(posedge clk) disable iff (rst)
    (!caller_waiting && $past(!caller_waiting)) |-> call_rst);

  assert_call_entry_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(caller_waiting) |-> call_rst);

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (caller_waiting && !callee_fin) |=> $stable(caller_state));

  assert_leave_on_fin_R4: assert property (@(posedge clk) disable iff (rst)
    (caller_waiting && callee_fin) |=> !caller_waiting);

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (caller_waiting && callee_fin) |=> capture == $past(callee_ret));

  assert_fin_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    callee_fin |=> !callee_fin);

  assert_sum_R5: assert property (@(posedge clk) disable iff (rst)
    callee_fin |-> callee_ret == WIDTH'(arg_b + arg_a));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fin_in_wait_R8: assert property (@(posedge clk) disable iff (rst)
    callee_fin |-> (caller_waiting && fin_count < 2'd2));

  assert_two_returns_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> fin_count == 2'd2);

endmodule

bind shared_call_top shared_call_checker #(.WIDTH(WIDTH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .done           (done),
  .result         (result),
  .call_rst       (call_rst),
  .arg_a          (arg_a),
  .arg_b          (arg_b),
  .callee_fin     (callee_fin),
  .callee_ret     (callee_ret),
  .capture        (capture),
  .caller_state   (caller_state),
  .caller_waiting (caller_waiting)
);

// File: tb/shared_call_top_bench.sv
module shared_call_top_bench;

  localparam int DONE_EDGE = 16;
  localparam int RUN_EDGES = 22;

  localparam logic [31:0] E32  = 32'd0 + 32'd1 + 32'd2;
  localparam logic [7:0]  E8   = 8'((200 + 50 + 10) % 256);
  localparam logic [31:0] ESAT = 32'((64'hFFFF_FFFF + 64'd2 + 64'd5) % 64'h1_0000_0000);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        done_a, done_b, done_c;
  logic [31:0] res_a;
  logic [7:0]  res_b;
  logic [31:0] res_c;
  int          checks = 0;
  int          fails  = 0;
  int          cycles = 0;

  always #10 clk = ~clk;

  shared_call_top u_shared_call_top (
    .clk(clk), .rst(rst), .done(done_a), .result(res_a)
  );

  shared_call_top #(
    .WIDTH(8), .FIRST_A(8'd200), .FIRST_B(8'd50), .SECOND_B(8'd10)
  ) u_shared_call_top_w8 (
    .clk(clk), .rst(rst), .done(done_b), .result(res_b)
  );

  shared_call_top #(
    .WIDTH(32), .FIRST_A(32'hFFFF_FFFF), .FIRST_B(32'd2), .SECOND_B(32'd5)
  ) u_shared_call_top_sat (
    .clk(clk), .rst(rst), .done(done_c), .result(res_c)
  );

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Reset state of all instances (R1).
  task automatic check_reset_state(input string req);
    check(done_a == 1'b0 && done_b == 1'b0 && done_c == 1'b0, req,
          {done_a, done_b, done_c}, 0);
    check(res_a == 32'd0, req, res_a, 0);
    check(res_b == 8'd0, req, res_b, 0);
    check(res_c == 32'd0, req, res_c, 0);
  endtask

  // Release reset at a negedge and follow a full sequence (R2..R8).
  task automatic full_run();
    rst = 1'b0;
    for (int k = 1; k <= RUN_EDGES; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) check_reset_state("R1 first cycle after reset");
      // done timing shows both calls waited for finish: R2 R3 R4 R8
      check(done_a == (k == DONE_EDGE), "R7 R4 R8 done timing 32b", done_a, k == DONE_EDGE);
      check(done_b == (k == DONE_EDGE), "R7 R2 R3 done timing 8b", done_b, k == DONE_EDGE);
      check(done_c == (k == DONE_EDGE), "R7 done timing sat", done_c, k == DONE_EDGE);
      if (k >= DONE_EDGE) begin
        check(res_a == E32,  "R6 R5 result 0+1+2", res_a, E32);
        check(res_b == E8,   "R6 R5 result 8b wrap", res_b, E8);
        check(res_c == ESAT, "R6 R5 result 32b wrap", res_c, ESAT);
      end else if (k < DONE_EDGE - 1) begin
        check(res_a == 32'd0, "R6 result before done", res_a, 0);
      end
    end
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1 in reset");
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1 power-up");
    full_run();
    // Reset sweep: abort at every offset, then expect an identical run (R9).
    for (int off = 0; off <= DONE_EDGE + 1; off++) begin
      rst = 1'b0;
      for (int j = 0; j < off; j++) begin
        @(posedge clk);
      end
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_reset_state("R9 R1 abort reset");
      full_run();
    end
    finish_run();
  end

endmodule